// File: doc/BRIEF.md
# Serial Controller Interrupt Cause and Mask Unit

This block gathers the interrupt sources of a serial controller and turns them into one interrupt request line. Five level status signals come from the FIFOs: receive at trigger level, receive empty, receive full, transmit empty and transmit full. Five single-cycle event pulses come from the receive path and the modem logic: receive overrun, framing error, parity error, receive timeout and modem status change. Every source sets a sticky bit in a ten-bit cause register. That bit stays set until software clears it by writing a one to it.

Software chooses which causes may raise the interrupt. It does this through a ten-bit mask that it can never write directly. One register offset sets mask bits and another clears them. The mask and cause registers are always visible on output ports, so a bus wrapper can return them on a read. The interrupt line is registered and is high while any cause bit is both set and enabled.

Top module: `uart_irq_ctrl`

## Requirements
- R1: Cause bits 4 down to 0 take `lvl_status[4:0]` in this order: bit 0 is receive trigger, bit 1 is receive empty, bit 2 is receive full, bit 3 is transmit empty and bit 4 is transmit full. Cause bits 9 down to 5 take `evt_pulse[4:0]` in this order: bit 5 is overrun, bit 6 is framing error, bit 7 is parity error, bit 8 is timeout and bit 9 is modem change.
- R2: A level status input that is high at a clock edge sets its cause bit at that edge. The bit stays set after the input falls.
- R3: An event pulse that is high at a clock edge sets its cause bit at that edge. The bit stays set after the pulse ends.
- R4: A write to offset 0x08 ORs `wr_data[9:0]` into the mask at that edge. Data bits 31 to 10 are ignored.
- R5: A write to offset 0x0C clears every mask bit for which `wr_data[9:0]` holds a one. All other mask bits keep their value.
- R6: A write to offset 0x10 leaves the mask and the cause unchanged, and so does a write to any offset other than 0x08, 0x0C or 0x14.
- R7: A write to offset 0x14 clears every cause bit for which `wr_data[9:0]` holds a one.
- R8: If a cause bit is cleared by a write and its source is asserted in the same cycle, the bit ends up set.
- R9: `irq_out` at each edge takes the OR over all bits of (mask AND cause) as they were before that edge. The output therefore follows a register change one cycle later.
- R10: While `rst_n` is low at a clock edge, the mask, the cause and `irq_out` all become zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| lvl_status | input | 5 | FIFO level status inputs |
| evt_pulse | input | 5 | Single-cycle error and event pulses |
| wr_en | input | 1 | Register write strobe |
| wr_offset | input | 8 | Byte offset of the write |
| wr_data | input | 32 | Write data |
| irq_mask | output | 10 | Current mask register |
| irq_cause | output | 10 | Current sticky cause register |
| irq_out | output | 1 | Registered interrupt request |

## Verification
The bound checker tests the following on every cycle:
- every asserted source is captured in the cause register one edge later,
- mask set and clear writes affect exactly the selected bits,
- a clear of the cause never removes a bit whose source is active in the same cycle,
- the interrupt line equals the masked OR of the previous cycle,
- reset zeroes all state.

Three behaviours can only be shown by the bench's scenarios:
- a cause bit stays set over many idle cycles after its source has gone away,
- writes to the read-only mask offset or to unused offsets leave the mask and the cause unchanged,
- the masked interrupt line rises and falls with the expected one-cycle lag across a full sequence of enable, clear and disable writes.

// File: rtl/uirq_pkg.sv
package uirq_pkg;
    localparam int LVL_W   = 5;
    localparam int EVT_W   = 5;
    localparam int CAUSE_W = LVL_W + EVT_W;
    localparam int DATA_W  = 32;
    localparam int OFF_W   = 8;

    localparam logic [OFF_W-1:0] OFF_MASK_SET = 8'h08;
    localparam logic [OFF_W-1:0] OFF_MASK_CLR = 8'h0C;
    localparam logic [OFF_W-1:0] OFF_MASK_RO  = 8'h10;
    localparam logic [OFF_W-1:0] OFF_CAUSE    = 8'h14;

    typedef struct packed {
        logic [CAUSE_W-1:0] set_mask;
        logic [CAUSE_W-1:0] clr_mask;
        logic [CAUSE_W-1:0] clr_cause;
    } wr_cmd_t;
endpackage

// File: rtl/uirq_wr_decode.sv
module uirq_wr_decode
    import uirq_pkg::*;
#(
    parameter int OW = OFF_W,
    parameter int DW = DATA_W,
    parameter int CW = CAUSE_W
) (
    input  logic          wr_en,
    input  logic [OW-1:0] wr_offset,
    input  logic [DW-1:0] wr_data,
    output logic [CW-1:0] set_mask,
    output logic [CW-1:0] clr_mask,
    output logic [CW-1:0] clr_cause
);
    logic [CW-1:0] payload;
    assign payload = wr_data[CW-1:0];

    always_comb begin
        set_mask  = '0;
        clr_mask  = '0;
        clr_cause = '0;
        if (wr_en) begin
            // The read-only mask offset and unused offsets decode to nothing.
            unique case (wr_offset)
                OW'(OFF_MASK_SET): set_mask  = payload;
                OW'(OFF_MASK_CLR): clr_mask  = payload;
                OW'(OFF_CAUSE):    clr_cause = payload;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/uirq_cause_reg.sv
module uirq_cause_reg
    import uirq_pkg::*;
#(
    parameter int LW = LVL_W,
    parameter int EW = EVT_W,
    localparam int CW = LW + EW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [LW-1:0] lvl_status,
    input  logic [EW-1:0] evt_pulse,
    input  logic [CW-1:0] clr_bits,
    output logic [CW-1:0] cause_q
);
    typedef struct packed {
        logic [CW-1:0] cause;
    } cause_state_t;

    cause_state_t st_d, st_q;
    logic [CW-1:0] src_vec;

    assign src_vec = {evt_pulse, lvl_status};

    // Each sticky cell: the clear is applied first, then the source sets the bit again.
    for (genvar b = 0; b < CW; b++) begin : g_cell
        always_comb begin
            st_d.cause[b] = (st_q.cause[b] & ~clr_bits[b]) | src_vec[b];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cause_q = st_q.cause;
endmodule

// File: rtl/uirq_mask_reg.sv
module uirq_mask_reg
    import uirq_pkg::*;
#(
    parameter int CW = CAUSE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] set_bits,
    input  logic [CW-1:0] clr_bits,
    output logic [CW-1:0] mask_q
);
    typedef struct packed {
        logic [CW-1:0] mask;
    } mask_state_t;

    mask_state_t st_d, st_q;

    always_comb begin
        st_d.mask = (st_q.mask | set_bits) & ~clr_bits;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mask_q = st_q.mask;
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
    import uirq_pkg::*;
#(
    parameter int LW = LVL_W,
    parameter int EW = EVT_W,
    parameter int OW = OFF_W,
    parameter int DW = DATA_W,
    localparam int CW = LW + EW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [LW-1:0] lvl_status,
    input  logic [EW-1:0] evt_pulse,
    input  logic          wr_en,
    input  logic [OW-1:0] wr_offset,
    input  logic [DW-1:0] wr_data,
    output logic [CW-1:0] irq_mask,
    output logic [CW-1:0] irq_cause,
    output logic          irq_out
);
    typedef struct packed {
        logic irq;
    } top_state_t;

    logic [CW-1:0] set_mask, clr_mask, clr_cause;
    top_state_t st_d, st_q;

    uirq_wr_decode #(.OW(OW), .DW(DW), .CW(CW)) u_decode (
        .wr_en     (wr_en),
        .wr_offset (wr_offset),
        .wr_data   (wr_data),
        .set_mask  (set_mask),
        .clr_mask  (clr_mask),
        .clr_cause (clr_cause)
    );

    uirq_cause_reg #(.LW(LW), .EW(EW)) u_cause (
        .clk        (clk),
        .rst_n      (rst_n),
        .lvl_status (lvl_status),
        .evt_pulse  (evt_pulse),
        .clr_bits   (clr_cause),
        .cause_q    (irq_cause)
    );

    uirq_mask_reg #(.CW(CW)) u_mask (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_bits (set_mask),
        .clr_bits (clr_mask),
        .mask_q   (irq_mask)
    );

    always_comb begin
        st_d.irq = |(irq_mask & irq_cause);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq_out = st_q.irq;
endmodule

// File: rtl/uirq_ctrl_chk.sv
module uirq_ctrl_chk
    import uirq_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic [LVL_W-1:0]   lvl_status,
    input logic [EVT_W-1:0]   evt_pulse,
    input logic               wr_en,
    input logic [OFF_W-1:0]   wr_offset,
    input logic [DATA_W-1:0]  wr_data,
    input logic [CAUSE_W-1:0] irq_mask,
    input logic [CAUSE_W-1:0] irq_cause,
    input logic               irq_out
);
    assert_lvl_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (|lvl_status) |=> ((irq_cause[LVL_W-1:0] & $past(lvl_status)) == $past(lvl_status)));

    assert_evt_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt_pulse) |=> ((irq_cause[CAUSE_W-1:LVL_W] & $past(evt_pulse)) == $past(evt_pulse)));

    assert_mask_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_offset == OFF_MASK_SET) |=>
            ((irq_mask & $past(wr_data[CAUSE_W-1:0])) == $past(wr_data[CAUSE_W-1:0])));

    assert_mask_clr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_offset == OFF_MASK_CLR) |=>
            ((irq_mask & $past(wr_data[CAUSE_W-1:0])) == '0));

    assert_mask_ro_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_offset == OFF_MASK_RO) |=> $stable(irq_mask));

    // The cleared bits are gone unless their source fired in the same cycle (R7, R8).
    assert_cause_w1c_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_offset == OFF_CAUSE) |=>
            ((irq_cause & $past(wr_data[CAUSE_W-1:0]) & ~$past({evt_pulse, lvl_status})) == '0));

    assert_new_event_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_offset == OFF_CAUSE && (|lvl_status)) |=>
            ((irq_cause[LVL_W-1:0] & $past(lvl_status)) == $past(lvl_status)));

    assert_irq_lag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_out == $past(|(irq_mask & irq_cause))));

    assert_reset_clear_R10: assert property (@(posedge clk)
        !rst_n |=> (irq_mask == '0 && irq_cause == '0 && !irq_out));
endmodule

bind uart_irq_ctrl uirq_ctrl_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .lvl_status (lvl_status),
    .evt_pulse  (evt_pulse),
    .wr_en      (wr_en),
    .wr_offset  (wr_offset),
    .wr_data    (wr_data),
    .irq_mask   (irq_mask),
    .irq_cause  (irq_cause),
    .irq_out    (irq_out)
);

// File: tb/uart_irq_ctrl_tb_top.sv
module uart_irq_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  lvl_status = '0;
    logic [4:0]  evt_pulse = '0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_offset = '0;
    logic [31:0] wr_data = '0;
    logic [9:0]  irq_mask, irq_cause;
    logic        irq_out;

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_irq_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .lvl_status(lvl_status), .evt_pulse(evt_pulse),
        .wr_en(wr_en), .wr_offset(wr_offset), .wr_data(wr_data),
        .irq_mask(irq_mask), .irq_cause(irq_cause), .irq_out(irq_out)
    );

    int checks = 0;
    int fails  = 0;
    logic [9:0] m_mask = '0, m_cause = '0;
    logic [20:0] exp_q[$];
    string       tag_q[$];

    // Driver: applies one cycle of stimulus and queues the expected post-edge state.
    task automatic step(input logic [4:0] l, input logic [4:0] e, input logic we,
                        input logic [7:0] off, input logic [31:0] d, input string tag);
        logic [9:0] nm, nc;
        logic       ni;
        @(negedge clk);
        lvl_status = l; evt_pulse = e; wr_en = we; wr_offset = off; wr_data = d;
        nc = m_cause;
        if (we && off == 8'h14) nc = nc & ~d[9:0];
        nc = nc | {e, l};
        nm = m_mask;
        if (we && off == 8'h08) nm = nm | d[9:0];
        if (we && off == 8'h0C) nm = nm & ~d[9:0];
        ni = |(m_mask & m_cause);
        m_mask = nm; m_cause = nc;
        exp_q.push_back({nm, nc, ni});
        tag_q.push_back(tag);
    endtask

    task automatic idle(input string tag);
        step(5'h0, 5'h0, 1'b0, 8'h00, 32'h0, tag);
    endtask

    // Monitor: pops one expected item per cycle and compares just after the edge.
    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            logic [20:0] ex;
            logic [20:0] act;
            string tg;
            ex = exp_q.pop_front();
            tg = tag_q.pop_front();
            act = {irq_mask, irq_cause, irq_out};
            checks++;
            if (act !== ex) begin
                fails++;
                $display("FAIL %s: mask/cause/irq actual=%h/%h/%b expected=%h/%h/%b",
                         tg, act[20:11], act[10:1], act[0], ex[20:11], ex[10:1], ex[0]);
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 50000);
        checks++; fails++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if ({irq_mask, irq_cause, irq_out} !== 21'h0) begin
            fails++;
            $display("FAIL R10: reset state actual=%h/%h/%b expected=0/0/0",
                     irq_mask, irq_cause, irq_out);
        end
        rst_n = 1'b1;
        idle("R10 idle after reset");
        // R1, R2: receive trigger level sets bit 0 and stays set
        step(5'b00001, 5'h0, 1'b0, 8'h00, 32'h0, "R1 R2 level bit0 capture");
        idle("R2 sticky after level falls");
        idle("R2 still sticky");
        // R1, R3: overrun pulse lands in bit 5
        step(5'h0, 5'b00001, 1'b0, 8'h00, 32'h0, "R1 R3 overrun pulse bit5");
        idle("R3 sticky after pulse");
        // R4: enable bit 0 only, upper data bits ignored
        step(5'h0, 5'h0, 1'b1, 8'h08, 32'hFFFF_FC01, "R4 mask set bit0");
        idle("R9 irq rises one cycle later");
        // R6: read-only mask offset and unused offset
        step(5'h0, 5'h0, 1'b1, 8'h10, 32'h0000_03FF, "R6 write to read-only mask");
        step(5'h0, 5'h0, 1'b1, 8'h00, 32'h0000_03FF, "R6 write to unused offset");
        step(5'h0, 5'h0, 1'b1, 8'h24, 32'h0000_03FF, "R6 write to other offset");
        // R5: clear mask bit 0
        step(5'h0, 5'h0, 1'b1, 8'h0C, 32'h0000_0001, "R5 mask clear bit0");
        idle("R9 irq falls one cycle later");
        // R7: clear cause bit 0
        step(5'h0, 5'h0, 1'b1, 8'h14, 32'h0000_0001, "R7 cause w1c bit0");
        // R8: clear bit5 while overrun pulses again
        step(5'h0, 5'b00001, 1'b1, 8'h14, 32'h0000_0020, "R8 pulse wins over clear");
        // R8: clear bit3 while transmit empty is high
        step(5'b01000, 5'h0, 1'b1, 8'h14, 32'h0000_0008, "R8 level wins over clear");
        // R1, R2, R3: mixed pattern
        step(5'b10110, 5'b01001, 1'b0, 8'h00, 32'h0, "R1 mixed sources");
        idle("R2 R3 mixed sticky");
        // R4, R9: enable all, then clear all causes
        step(5'h0, 5'h0, 1'b1, 8'h08, 32'h0000_03FF, "R4 mask set all");
        idle("R9 irq with all enabled");
        step(5'h0, 5'h0, 1'b1, 8'h14, 32'hFFFF_FFFF, "R7 clear all causes");
        idle("R9 irq drops after clear");
        idle("R9 irq stays low");
        // R9: modem change with only bit9 enabled
        step(5'h0, 5'h0, 1'b1, 8'h0C, 32'h0000_01FF, "R5 clear lower mask bits");
        step(5'h0, 5'b10000, 1'b0, 8'h00, 32'h0, "R3 modem change bit9");
        idle("R9 irq from bit9");
        step(5'b00001, 5'h0, 1'b0, 8'h00, 32'h0, "R9 masked cause no irq change");
        idle("R9 final");
        // R10: reset mid-run
        @(negedge clk);
        rst_n = 1'b0; wr_en = 1'b0; lvl_status = '0; evt_pulse = '0;
        @(negedge clk);
        checks++;
        if ({irq_mask, irq_cause, irq_out} !== 21'h0) begin
            fails++;
            $display("FAIL R10: mid-run reset actual=%h/%h/%b expected=0/0/0",
                     irq_mask, irq_cause, irq_out);
        end
        repeat (2) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule